// File: doc/BRIEF.md
# Five-Voice Wavetable Register Decoder

This block sits between a byte-wide host bus and the oscillators of a five-voice wavetable sound generator. Each bus access carries an 8-bit address. The upper three address bits pick one of eight 32-byte regions, and the lower five bits pick a byte inside that region. The block keeps a copy of every voice's 32-byte waveform so that it can answer reads. For every accepted waveform write it issues a per-voice write strobe with the byte address and data. It holds each voice's 12-bit period, 4-bit volume and enable bit. It also holds the test flags that the oscillators use: the short-counter modes, position reset on period writes, and the two rotate modes.

Two memory maps are selected by a mode input. In basic mode, voices 3 and 4 share one waveform, the control registers sit in region 4, the test register sits in region 7, and voice 4's waveform is read back through region 5. In extended mode, every voice has its own waveform in regions 0 to 4, the control registers move to region 5, and the test register moves to region 6. The oscillators report each voice's live waveform position. In the rotate modes, reads add that position to the requested byte.

Top module: `sndif_top`

## Requirements
- R1: In extended mode, a write to region r (0 to 4) at byte b asserts wave_we_o bit r for exactly one cycle, starting the cycle after the write, with wave_addr_o = b and wave_data_o equal to the written byte. A read of region r returns that voice's byte b on rdata_o one cycle after rd_i, and rdata_o holds that value until the next read.
- R2: In basic mode, a write to region 3 asserts wave_we_o bits 3 and 4 together and stores the byte for both voices. No region writes voice 4 alone. A read of region 5 returns voice 4's waveform.
- R3: The control region is region 4 in basic mode and region 5 in extended mode, and only address bits 3:0 decode it. Offset 2v sets the low 8 bits of voice v's period, and offset 2v+1 sets the high 4 bits from data bits 3:0. Offsets 0xA to 0xE set the volume of voices 0 to 4 from data bits 3:0. Offset 0xF sets the five enable bits from data bits 4:0. The outputs change one cycle after the write.
- R4: The test register is region 7 in basic mode and region 6 in extended mode. Each data bit drives one flag: bit 0 drives cnt4_o, bit 1 drives cnt8_o, bit 5 drives pos_reset_o, bit 6 drives rotate_o, and bit 7 drives rotate_pair_o. A test write in extended mode leaves rotate_pair_o unchanged.
- R5: A period byte write to voice v while pos_reset_o is set pulses pos_clr_o bit v for one cycle. The pulse comes in the same cycle as the period update.
- R6: While rotate_o is set, no waveform write takes effect in either mode. No strobe is issued and the stored bytes are unchanged.
- R7: While rotate_o is set, a read of voice v at byte b returns stored byte (b + pos_v) mod 32, where pos_v is voice v's field of voice_pos_i.
- R8: In basic mode, rotate_pair_o blocks writes to region 3. It also offsets reads of region 3 by voice 3's position, or by voice 4's position when rotate_o is also set. Reads of other regions are not offset by rotate_pair_o. In extended mode, rotate_pair_o has no effect on writes or reads.
- R9: Reads of unmapped regions return 0xFF. In basic mode these are regions 4, 6 and 7. In extended mode they are regions 5, 6 and 7.
- R10: After reset, all outputs, flags and stored waveform bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the extended map, 0 the basic map |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Bus address: region in bits 7:5, byte in bits 4:0 |
| wdata_i | input | 8 | Write data |
| voice_pos_i | input | 25 | Live waveform position of each voice, 5 bits per voice, voice v at bits 5v+4:5v |
| rdata_o | output | 8 | Registered read data |
| wave_we_o | output | 5 | Per-voice waveform write strobe |
| wave_addr_o | output | 5 | Waveform byte address for the strobe |
| wave_data_o | output | 8 | Waveform byte for the strobe |
| period_o | output | 60 | Per-voice 12-bit period, voice v at bits 12v+11:12v |
| volume_o | output | 20 | Per-voice 4-bit volume, voice v at bits 4v+3:4v |
| enable_o | output | 5 | Per-voice enable |
| cnt4_o | output | 1 | 4-bit counter mode flag |
| cnt8_o | output | 1 | 8-bit counter mode flag |
| pos_reset_o | output | 1 | Position reset on period write flag |
| rotate_o | output | 1 | Rotate flag for all voices |
| rotate_pair_o | output | 1 | Rotate flag for voices 3 and 4, basic mode only |
| pos_clr_o | output | 5 | One-cycle per-voice position clear pulse |

## Verification
Every result is due exactly one clock edge after the access that causes it. This covers read data, write strobes, register outputs, flags and the position clear pulse, because each comes from a single register stage. The bench's behavioural model updates its expected state at the same rising edge as the design, and the outputs are compared at the next falling edge, before new stimulus can take effect. Directed checks issue an access, wait one idle cycle, and then sample. A read that coincides with a test-register write uses the flags held before that write, in both the model and the design.

// File: rtl/sndif_pkg.sv
package sndif_pkg;
  localparam int NV   = 5;   // voices
  localparam int DW   = 8;   // bus data width
  localparam int AW   = 8;   // bus address width
  localparam int WAW  = 5;   // waveform byte address width
  localparam int PW   = 12;  // period width
  localparam int VW   = 4;   // volume width
  localparam int RW   = AW - WAW;
  localparam int VIW  = $clog2(NV);
  localparam int WLEN = 1 << WAW;

  localparam logic [VIW-1:0] SH_A = VIW'(NV - 2);  // shared pair in basic map
  localparam logic [VIW-1:0] SH_B = VIW'(NV - 1);

  localparam logic [RW-1:0] B_SHARED = 3'd3;
  localparam logic [RW-1:0] B_CTRL   = 3'd4;
  localparam logic [RW-1:0] B_V4_RD  = 3'd5;
  localparam logic [RW-1:0] B_TEST   = 3'd7;
  localparam logic [RW-1:0] X_CTRL   = 3'd5;
  localparam logic [RW-1:0] X_TEST   = 3'd6;

  typedef struct packed {
    logic           wave_hit;
    logic           shared;
    logic [VIW-1:0] wave_v;
    logic           ctrl_hit;
    logic           test_hit;
    logic           rd_hit;
    logic [VIW-1:0] rd_v;
  } dec_t;
endpackage

// File: rtl/sndif_decode.sv
module sndif_decode
  import sndif_pkg::*;
(
  input  logic          ext_i,
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  logic [RW-1:0] reg_sel;
  assign reg_sel = addr_i[AW-1:WAW];

  always_comb begin
    dec_o = '0;
    if (ext_i) begin
      dec_o.wave_hit = int'(reg_sel) < NV;
      dec_o.wave_v   = reg_sel;
      dec_o.ctrl_hit = reg_sel == X_CTRL;
      dec_o.test_hit = reg_sel == X_TEST;
      dec_o.rd_hit   = int'(reg_sel) < NV;
      dec_o.rd_v     = reg_sel;
    end else begin
      dec_o.wave_hit = reg_sel <= B_SHARED;
      dec_o.shared   = reg_sel == B_SHARED;
      dec_o.wave_v   = reg_sel;
      dec_o.ctrl_hit = reg_sel == B_CTRL;
      dec_o.test_hit = reg_sel == B_TEST;
      dec_o.rd_hit   = (reg_sel <= B_SHARED) || (reg_sel == B_V4_RD);
      dec_o.rd_v     = (reg_sel == B_V4_RD) ? SH_B : reg_sel;
    end
  end
endmodule

// File: rtl/sndif_regs.sv
module sndif_regs
  import sndif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  dec_t             dec_i,
  output logic [NV*PW-1:0] period_o,
  output logic [NV*VW-1:0] volume_o,
  output logic [NV-1:0]    enable_o,
  output logic             cnt4_o,
  output logic             cnt8_o,
  output logic             pos_reset_o,
  output logic             rotate_o,
  output logic             rotate_pair_o,
  output logic [NV-1:0]    pos_clr_o
);
  localparam logic [3:0] OFF_VOL = 4'(2 * NV);
  localparam logic [3:0] OFF_EN  = 4'hF;

  logic [PW-1:0] per_q [NV];
  logic [VW-1:0] vol_q [NV];
  logic [3:0]    off;
  logic [3:0]    vol_off;
  logic          per_wr;

  assign off     = addr_i[3:0];
  assign vol_off = off - OFF_VOL;
  assign per_wr  = wr_i && dec_i.ctrl_hit && (off < OFF_VOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < NV; v++) begin
        per_q[v] <= '0;
        vol_q[v] <= '0;
      end
      enable_o      <= '0;
      cnt4_o        <= 1'b0;
      cnt8_o        <= 1'b0;
      pos_reset_o   <= 1'b0;
      rotate_o      <= 1'b0;
      rotate_pair_o <= 1'b0;
      pos_clr_o     <= '0;
    end else begin
      pos_clr_o <= '0;
      if (per_wr) begin
        if (off[0]) per_q[off[3:1]][PW-1:DW] <= wdata_i[PW-DW-1:0];
        else        per_q[off[3:1]][DW-1:0]  <= wdata_i;
        if (pos_reset_o) pos_clr_o[off[3:1]] <= 1'b1;
      end else if (wr_i && dec_i.ctrl_hit && off != OFF_EN) begin
        vol_q[vol_off[VIW-1:0]] <= wdata_i[VW-1:0];
      end else if (wr_i && dec_i.ctrl_hit) begin
        enable_o <= wdata_i[NV-1:0];
      end
      if (wr_i && dec_i.test_hit) begin
        cnt4_o      <= wdata_i[0];
        cnt8_o      <= wdata_i[1];
        pos_reset_o <= wdata_i[5];
        rotate_o    <= wdata_i[6];
        if (!ext_i) rotate_pair_o <= wdata_i[7];
      end
    end
  end

  for (genvar v = 0; v < NV; v++) begin : g_out
    assign period_o[v*PW +: PW] = per_q[v];
    assign volume_o[v*VW +: VW] = vol_q[v];
  end

  // R5
  clr_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pos_clr_o) |-> $past(pos_reset_o) && $past(wr_i) && $past(dec_i.ctrl_hit));
  // R5
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pos_clr_o));
  // R4
  pair_kept_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && dec_i.test_hit && ext_i) |-> $stable(rotate_pair_o));
endmodule

// File: rtl/sndif_wave.sv
module sndif_wave
  import sndif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NV*WAW-1:0] voice_pos_i,
  input  dec_t              dec_i,
  input  logic              rot_i,
  input  logic              rot4_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NV-1:0]     wave_we_o,
  output logic [WAW-1:0]    wave_addr_o,
  output logic [DW-1:0]     wave_data_o
);
  logic [DW-1:0]  mem [NV][WLEN];
  logic [WAW-1:0] pos [NV];
  logic [NV-1:0]  we_c;
  logic [VIW-1:0] pos_sel;
  logic           use_off;
  logic [WAW-1:0] eff;

  for (genvar v = 0; v < NV; v++) begin : g_pos
    assign pos[v] = voice_pos_i[v*WAW +: WAW];
  end

  always_comb begin
    we_c = '0;
    if (wr_i && dec_i.wave_hit && !rot_i) begin
      if (dec_i.shared) begin
        if (!rot4_i) begin
          we_c[SH_A] = 1'b1;
          we_c[SH_B] = 1'b1;
        end
      end else begin
        we_c[dec_i.wave_v] = 1'b1;
      end
    end
  end

  always_comb begin
    pos_sel = dec_i.rd_v;
    use_off = rot_i;
    if (!ext_i && dec_i.rd_v == SH_A && (rot_i || rot4_i)) begin
      use_off = 1'b1;
      pos_sel = rot_i ? SH_B : SH_A;
    end
    eff = addr_i[WAW-1:0] + (use_off ? pos[pos_sel] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < NV; v++)
        for (int b = 0; b < WLEN; b++) mem[v][b] <= '0;
      rdata_o     <= '0;
      wave_we_o   <= '0;
      wave_addr_o <= '0;
      wave_data_o <= '0;
    end else begin
      wave_we_o <= we_c;
      if (|we_c) begin
        wave_addr_o <= addr_i[WAW-1:0];
        wave_data_o <= wdata_i;
      end
      for (int v = 0; v < NV; v++)
        if (we_c[v]) mem[v][addr_i[WAW-1:0]] <= wdata_i;
      if (rd_i) rdata_o <= dec_i.rd_hit ? mem[dec_i.rd_v][eff] : '1;
    end
  end

  // R6
  no_we_in_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wave_we_o) |-> !$past(rot_i));
  // R2
  shared_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_we_o[SH_A] || wave_we_o[SH_B]) && !$past(ext_i) |-> wave_we_o[SH_A] && wave_we_o[SH_B]);
  // R8
  pair_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wave_we_o[SH_A] && !$past(ext_i) |-> !$past(rot4_i));
  // R9
  unmapped_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && !dec_i.rd_hit) |-> rdata_o == '1);
  // R1
  we_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wave_we_o) <= 2);
endmodule

// File: rtl/sndif_top.sv
module sndif_top
  import sndif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NV*WAW-1:0] voice_pos_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NV-1:0]     wave_we_o,
  output logic [WAW-1:0]    wave_addr_o,
  output logic [DW-1:0]     wave_data_o,
  output logic [NV*PW-1:0]  period_o,
  output logic [NV*VW-1:0]  volume_o,
  output logic [NV-1:0]     enable_o,
  output logic              cnt4_o,
  output logic              cnt8_o,
  output logic              pos_reset_o,
  output logic              rotate_o,
  output logic              rotate_pair_o,
  output logic [NV-1:0]     pos_clr_o
);
  dec_t dec;

  sndif_decode u_dec (
    .ext_i (ext_mode_i),
    .addr_i(addr_i),
    .dec_o (dec)
  );

  sndif_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_i        (ext_mode_i),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .dec_i        (dec),
    .period_o     (period_o),
    .volume_o     (volume_o),
    .enable_o     (enable_o),
    .cnt4_o       (cnt4_o),
    .cnt8_o       (cnt8_o),
    .pos_reset_o  (pos_reset_o),
    .rotate_o     (rotate_o),
    .rotate_pair_o(rotate_pair_o),
    .pos_clr_o    (pos_clr_o)
  );

  sndif_wave u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_mode_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .voice_pos_i(voice_pos_i),
    .dec_i      (dec),
    .rot_i      (rotate_o),
    .rot4_i     (rotate_pair_o),
    .rdata_o    (rdata_o),
    .wave_we_o  (wave_we_o),
    .wave_addr_o(wave_addr_o),
    .wave_data_o(wave_data_o)
  );
endmodule

// File: tb/sndif_top_test.sv
`timescale 1ns/1ps
module sndif_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [4:0]  pos [5];
  logic [24:0] pos_bus;
  logic [7:0]  rdata;
  logic [4:0]  we, clr, en;
  logic [4:0]  waddr;
  logic [7:0]  wdo;
  logic [59:0] per;
  logic [19:0] vol;
  logic        c4, c8, rp, ro, r4;

  int n_chk = 0, n_err = 0;
  bit running = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  assign pos_bus = {pos[4], pos[3], pos[2], pos[1], pos[0]};

  sndif_top uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .voice_pos_i(pos_bus), .rdata_o(rdata),
    .wave_we_o(we), .wave_addr_o(waddr), .wave_data_o(wdo), .period_o(per),
    .volume_o(vol), .enable_o(en), .cnt4_o(c4), .cnt8_o(c8), .pos_reset_o(rp),
    .rotate_o(ro), .rotate_pair_o(r4), .pos_clr_o(clr)
  );

  // behavioural reference model
  int mem [5][32];
  int m_per [5], m_vol [5];
  int m_en, m_c4, m_c8, m_rp, m_ro, m_r4;
  int e_we, e_clr, e_rd, e_wa, e_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mem[v, b]) mem[v][b] = 0;
      foreach (m_per[v]) begin m_per[v] = 0; m_vol[v] = 0; end
      m_en = 0; m_c4 = 0; m_c8 = 0; m_rp = 0; m_ro = 0; m_r4 = 0;
      e_we = 0; e_clr = 0; e_rd = 0; e_wa = 0; e_wd = 0;
    end else begin
      int rg, b, v, idx, o;
      rg = int'(addr[7:5]); b = int'(addr[4:0]); o = int'(addr[3:0]);
      e_we = 0; e_clr = 0;
      if (rd) begin
        if (ext ? (rg < 5) : (rg < 4 || rg == 5)) begin
          v = (!ext && rg == 5) ? 4 : rg;
          idx = b;
          if (m_ro != 0) idx = (b + int'(pos[v])) % 32;
          if (!ext && v == 3 && (m_ro != 0 || m_r4 != 0))
            idx = (b + int'(pos[(m_ro != 0) ? 4 : 3])) % 32;
          e_rd = mem[v][idx];
        end else e_rd = 255;
      end
      if (wr) begin
        if (m_ro == 0 && ((ext && rg < 5) || (!ext && rg < 3))) begin
          mem[rg][b] = int'(wdata); e_we = 1 << rg; e_wa = b; e_wd = int'(wdata);
        end else if (m_ro == 0 && m_r4 == 0 && !ext && rg == 3) begin
          mem[3][b] = int'(wdata); mem[4][b] = int'(wdata);
          e_we = 24; e_wa = b; e_wd = int'(wdata);
        end else if (rg == (ext ? 5 : 4)) begin
          if (o < 10) begin
            v = o / 2;
            if (o % 2 == 1) m_per[v] = (m_per[v] % 256) + 256 * (int'(wdata) % 16);
            else            m_per[v] = (m_per[v] / 256) * 256 + int'(wdata);
            if (m_rp != 0) e_clr = 1 << v;
          end else if (o < 15) m_vol[o - 10] = int'(wdata) % 16;
          else m_en = int'(wdata) % 32;
        end else if (rg == (ext ? 6 : 7)) begin
          m_c4 = int'(wdata[0]); m_c8 = int'(wdata[1]);
          m_rp = int'(wdata[5]); m_ro = int'(wdata[6]);
          if (!ext) m_r4 = int'(wdata[7]);
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk(cur_req, int'(we), e_we);
      if (e_we != 0) begin
        chk("R1 addr", int'(waddr), e_wa);
        chk("R1 data", int'(wdo), e_wd);
      end
      chk("R5", int'(clr), e_clr);
      chk(cur_req, int'(rdata), e_rd);
      for (int v = 0; v < 5; v++) begin
        chk("R3 period", int'(per[v*12 +: 12]), m_per[v]);
        chk("R3 volume", int'(vol[v*4 +: 4]), m_vol[v]);
      end
      chk("R3 enable", int'(en), m_en);
      chk("R4 flags", int'({r4, ro, rp, c8, c4}),
          m_r4 * 16 + m_ro * 8 + m_rp * 4 + m_c8 * 2 + m_c4);
    end
  end

  task automatic go(bit w, bit r, int a, int d);
    @(negedge clk);
    wr = w; rd = r; addr = 8'(a); wdata = 8'(d);
  endtask
  task automatic idle();
    go(0, 0, 0, 0);
  endtask
  task automatic wrt(int a, int d);
    go(1, 0, a, d); idle();
  endtask
  task automatic rdc(string req, int a, int exp);
    go(0, 1, a, 0); idle();
    chk(req, int'(rdata), exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    foreach (pos[v]) pos[v] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", int'(rdata), 0);
    chk("R10", int'(we), 0);
    chk("R10", int'(en), 0);
    chk("R10", int'({r4, ro, rp, c8, c4}), 0);
    chk("R10", int'(per), 0);
    chk("R10", int'(clr), 0);
    running = 1;

    cur_req = "R1"; ext = 1;
    go(1, 0, 8'h83, 8'hC3); idle();
    chk("R1", int'(we), 5'b10000);
    chk("R1", int'(waddr), 3);
    chk("R1", int'(wdo), 8'hC3);
    rdc("R1", 8'h83, 8'hC3);
    wrt(8'h1F, 8'h5A);
    rdc("R1", 8'h1F, 8'h5A);

    cur_req = "R2"; ext = 0;
    go(1, 0, 8'h65, 8'h77); idle();
    chk("R2", int'(we), 5'b11000);
    rdc("R2", 8'hA5, 8'h77);
    ext = 1;
    rdc("R2", 8'h85, 8'h77);

    cur_req = "R3"; ext = 0;
    wrt(8'h84, 8'h34); wrt(8'h85, 8'hF2); wrt(8'h9C, 8'hF9); wrt(8'h8F, 8'hFF);
    chk("R3", int'(per[24 +: 12]), 12'h234);
    chk("R3", int'(vol[8 +: 4]), 9);
    chk("R3", int'(en), 5'h1F);
    ext = 1;
    wrt(8'hA0, 8'h11); wrt(8'hAE, 8'h03); wrt(8'hAF, 8'h05);
    chk("R3", int'(per[0 +: 12]), 12'h011);
    chk("R3", int'(vol[16 +: 4]), 3);
    chk("R3", int'(en), 5);

    cur_req = "R4"; ext = 0;
    wrt(8'hE0, 8'h83);
    chk("R4", int'({r4, ro, rp, c8, c4}), 5'b10011);
    ext = 1;
    wrt(8'hC0, 8'h00);
    chk("R4", int'({r4, ro, rp, c8, c4}), 5'b10000);
    ext = 0;
    wrt(8'hE0, 8'h00);
    chk("R4", int'(r4), 0);

    cur_req = "R5";
    wrt(8'hE0, 8'h20);
    go(1, 0, 8'h86, 8'h44); idle();
    chk("R5", int'(clr), 5'b01000);
    idle();
    chk("R5", int'(clr), 0);
    wrt(8'hE0, 8'h00);

    cur_req = "R6"; ext = 1;
    wrt(8'hC0, 8'h40);
    go(1, 0, 8'h1F, 8'h99); idle();
    chk("R6", int'(we), 0);
    wrt(8'hC0, 8'h00);
    rdc("R6", 8'h1F, 8'h5A);

    cur_req = "R7";
    for (int k = 0; k < 32; k++) wrt(8'h20 + k, 8'h10 + k);
    pos[1] = 5'd7;
    wrt(8'hC0, 8'h40);
    rdc("R7", 8'h22, 8'h19);
    rdc("R7", 8'h3E, 8'h15);
    wrt(8'hC0, 8'h00);

    cur_req = "R8"; ext = 0;
    for (int k = 0; k < 32; k++) wrt(8'h60 + k, 8'h40 + k);
    pos[3] = 5'd2; pos[4] = 5'd9;
    wrt(8'hE0, 8'h80);
    rdc("R8", 8'h61, 8'h43);
    rdc("R8", 8'h22, 8'h12);
    go(1, 0, 8'h62, 8'hEE); idle();
    chk("R8", int'(we), 0);
    wrt(8'hE0, 8'hC0);
    rdc("R8", 8'h61, 8'h4A);
    wrt(8'hE0, 8'h00);
    ext = 1;
    wrt(8'hC0, 8'h00);
    rdc("R8", 8'h61, 8'h41);

    cur_req = "R9";
    ext = 0;
    rdc("R9", 8'h80, 8'hFF);
    rdc("R9", 8'hC0, 8'hFF);
    rdc("R9", 8'hE3, 8'hFF);
    ext = 1;
    rdc("R9", 8'hA0, 8'hFF);
    rdc("R9", 8'hC1, 8'hFF);
    rdc("R9", 8'hF0, 8'hFF);

    cur_req = "R1 mixed";
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 2));
      ext = 1'($urandom_range(0, 1));
      if (i % 50 == 0) pos[$urandom_range(0, 4)] = 5'($urandom);
      go(op == 0, op == 1, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end
    idle(); idle();
    finish_run();
  end
endmodule